// File: doc/BRIEF.md
# Page-mode DRAM access sequencer

This block sits on the host side of an asynchronous DRAM and turns a stream of column requests into row-strobe, column-strobe, write-enable, output-enable, multiplexed-address and data-pin activity. A request names a row, a column, a direction, write data and a write-mask word. The first request opens its row: the row address is set up, the mask word is placed on the data pins while the row strobe falls, and the column access follows. Later requests to the same row reuse the open row. Each one costs a single column-strobe pulse while the row strobe stays low.

The page is closed when one of three things happens: a request arrives for another row, no request arrives for `IDLE_MAX` cycles, or the next access would push the row-strobe low time past `RAS_MAX` cycles. A closed page is followed by at least `T_RP` cycles of precharge. Read data is registered at the end of the column-strobe pulse and returned with a one-cycle strobe. On the first access of a page the pulse also waits out the row-referenced access time. All timing counts are parameters in system clock cycles.

States and transitions: `ST_IDLE` (an accepted request goes to `ST_ROW_SETUP`) → `ST_ROW_SETUP` (after `T_ASR` cycles goes to `ST_RAS_FALL`) → `ST_RAS_FALL` (one cycle, goes to `ST_COL_SETUP`) → `ST_COL_SETUP` (after `T_ASC` cycles goes to `ST_CAS_LOW`) → `ST_CAS_LOW` (when access timing is met goes to `ST_CAS_HIGH`) → `ST_CAS_HIGH` (after `T_CP` cycles goes to `ST_PAGE_WAIT`). From `ST_PAGE_WAIT`, an accepted same-row request goes back to `ST_COL_SETUP`. A different-row request, the idle limit or an exhausted row-time budget goes to `ST_PRECHARGE`. `ST_PRECHARGE` returns to `ST_IDLE` after `T_RP` cycles.

Top module: `page_dram_seq`

## Requirements
- R1: After reset the row strobe, column strobe, write enable and output enable (all active low) are high, the data pins are not driven (`dram_dq_oe` = 0), `rd_valid` is 0 and `req_ready` is 1.
- R2: The row address is held on `dram_addr` for at least `T_ASR` cycles before the row strobe falls. When it falls, `dram_dq_oe` is 1 and `dram_dq_out` equals the mask word of the request that opened the row.
- R3: Requests to the open row are each served by one column-strobe pulse while the row strobe stays low. The column address is held at least `T_ASC` cycles before each pulse falls. The column strobe stays high for at least `T_CP` cycles between pulses.
- R4: On the first access of a page, read data is captured only once the column strobe has been low for `T_CAC` cycles and the row strobe for `T_RAC` cycles. The pulse lasts exactly the larger of `T_CAC` and `T_RAC-1-T_ASC` cycles.
- R5: On later accesses of a page, the column-strobe pulse lasts exactly `T_CAC` cycles and read data is captured at its end.
- R6: A write drives write enable low, `dram_dq_oe` high and the request data on `dram_dq_out` when the column strobe falls. A read holds write enable high and output enable low during the pulse.
- R7: Each read returns its captured data on `rd_data` with a one-cycle `rd_valid`, in request order.
- R8: A request to a row other than the open one closes the page in the first waiting cycle: the row strobe rises `T_CP+1` cycles after the column strobe rises. The request is served in a new page.
- R9: With no request pending, the page closes after `IDLE_MAX` waiting cycles: the row strobe rises `T_CP+IDLE_MAX` cycles after the last column-strobe rise.
- R10: The row strobe is never low for more than `RAS_MAX` cycles. A same-row request that cannot finish inside that budget is held off (`req_ready` = 0) and served after the page is closed.
- R11: The row strobe stays high for at least `T_RP` cycles between two pages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | DATA_W | Write-mask word, used by the request that opens a row |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | DATA_W | Registered read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_dq_out | output | DATA_W | Data or mask driven toward the DRAM |
| dram_dq_oe | output | 1 | Data pin drive enable |
| dram_dq_in | input | DATA_W | Data returned by the DRAM |

## Verification
The bench builds the block with `T_ASR`=2, `T_ASC`=1, `T_CAC`=2, `T_RAC`=6, `T_CP`=1, `T_RP`=3, `RAS_MAX`=40 and `IDLE_MAX`=5. Because `T_RAC` exceeds the row-fall-to-column-fall distance plus `T_CAC`, the first pulse of each page must stretch to four cycles while later pulses stay at two. The DRAM model returns correct data only when both access times are honoured. The 40-cycle budget lets a ten-request same-row burst reach the forced close after exactly seven pulses and a 38-cycle row-strobe low time. The short idle limit keeps the idle-close case within a few cycles.

// File: rtl/pds_pkg.sv
package pds_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW_SETUP,
        ST_RAS_FALL,
        ST_COL_SETUP,
        ST_CAS_LOW,
        ST_CAS_HIGH,
        ST_PAGE_WAIT,
        ST_PRECHARGE
    } pds_state_e;

    // States in which the row strobe is driven low.
    function automatic logic row_open(input pds_state_e s);
        return (s == ST_RAS_FALL) || (s == ST_COL_SETUP) || (s == ST_CAS_LOW) ||
               (s == ST_CAS_HIGH) || (s == ST_PAGE_WAIT);
    endfunction

endpackage

// File: rtl/pds_age_counter.sv
// Saturating cycle counter: 1 in the first cycle of a run, 0 when idle.
module pds_age_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         restart,
    output logic [W-1:0] age
);
    localparam logic [W-1:0] AGE_TOP = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= '0;
        end else if (!run) begin
            age <= '0;
        end else if (restart) begin
            age <= W'(1);
        end else if (age != AGE_TOP) begin
            age <= age + W'(1);
        end
    end
endmodule

// File: rtl/pds_rd_capture.sv
// Registers read data at the end of a read pulse and raises a one-cycle strobe.
module pds_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= capture;
            if (capture) begin
                rd_data <= dq_in;
            end
        end
    end
endmodule

// File: rtl/page_dram_seq.sv
module page_dram_seq
    import pds_pkg::*;
#(
    parameter int ROW_W    = 8,
    parameter int COL_W    = 8,
    parameter int DATA_W   = 8,
    parameter int T_ASR    = 2,
    parameter int T_ASC    = 1,
    parameter int T_CAC    = 2,
    parameter int T_RAC    = 6,
    parameter int T_CP     = 1,
    parameter int T_RP     = 3,
    parameter int RAS_MAX  = 1000,
    parameter int IDLE_MAX = 8,
    localparam int ADDR_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] req_mask,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [ADDR_W-1:0] dram_addr,
    output logic [DATA_W-1:0] dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DATA_W-1:0] dram_dq_in
);
    localparam int ACC_LEN = T_ASC + T_CAC + T_CP + 1;
    localparam int LIM     = RAS_MAX + IDLE_MAX + T_RP + T_RAC + T_ASR + T_CAC + T_CP + T_ASC;
    localparam int AGE_W   = $clog2(LIM + 2);

    localparam logic [AGE_W-1:0] ASR_A  = AGE_W'(T_ASR);
    localparam logic [AGE_W-1:0] ASC_A  = AGE_W'(T_ASC);
    localparam logic [AGE_W-1:0] CAC_A  = AGE_W'(T_CAC);
    localparam logic [AGE_W-1:0] RAC_A  = AGE_W'(T_RAC);
    localparam logic [AGE_W-1:0] CP_A   = AGE_W'(T_CP);
    localparam logic [AGE_W-1:0] RP_A   = AGE_W'(T_RP);
    localparam logic [AGE_W-1:0] IDLE_A = AGE_W'(IDLE_MAX);
    localparam logic [AGE_W-1:0] MAX_A  = AGE_W'(RAS_MAX);
    localparam logic [AGE_W:0]   ACC_B  = (AGE_W + 1)'(ACC_LEN);
    localparam logic [AGE_W:0]   MAX_B  = (AGE_W + 1)'(RAS_MAX);

    pds_state_e state_q, state_d;

    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic              wr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] mask_q;
    logic              first_q;

    logic [AGE_W-1:0]  st_age;
    logic [AGE_W-1:0]  ras_age;

    logic accept;
    logic budget_ok;
    logic same_row;
    logic cas_done;
    logic capture;

    // ---------------- cycle counters ----------------
    pds_age_counter #(.W(AGE_W)) u_state_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (1'b1),
        .restart (state_d != state_q),
        .age     (st_age)
    );

    pds_age_counter #(.W(AGE_W)) u_row_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (row_open(state_d)),
        .restart (!row_open(state_q)),
        .age     (ras_age)
    );

    // ---------------- decisions ----------------
    assign same_row  = (req_row == row_q);
    assign budget_ok = ({1'b0, ras_age} + ACC_B) <= MAX_B;
    assign cas_done  = (st_age >= CAC_A) && (!first_q || (ras_age >= RAC_A));
    assign accept    = req_valid && req_ready;
    assign capture   = (state_q == ST_CAS_LOW) && cas_done && !wr_q;

    always_comb begin
        unique case (state_q)
            ST_IDLE:      req_ready = 1'b1;
            ST_PAGE_WAIT: req_ready = same_row && budget_ok;
            default:      req_ready = 1'b0;
        endcase
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = ST_ROW_SETUP;
            end
            ST_ROW_SETUP: begin
                if (st_age >= ASR_A) state_d = ST_RAS_FALL;
            end
            ST_RAS_FALL: begin
                state_d = ST_COL_SETUP;
            end
            ST_COL_SETUP: begin
                if (st_age >= ASC_A) state_d = ST_CAS_LOW;
            end
            ST_CAS_LOW: begin
                if (cas_done) state_d = ST_CAS_HIGH;
            end
            ST_CAS_HIGH: begin
                if (st_age >= CP_A) state_d = ST_PAGE_WAIT;
            end
            ST_PAGE_WAIT: begin
                if (req_valid) begin
                    state_d = (same_row && budget_ok) ? ST_COL_SETUP : ST_PRECHARGE;
                end else if (!budget_ok || (st_age >= IDLE_A)) begin
                    state_d = ST_PRECHARGE;
                end
            end
            ST_PRECHARGE: begin
                if (st_age >= RP_A) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- state and request registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            row_q   <= '0;
            col_q   <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            mask_q  <= '0;
            first_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                col_q   <= req_col;
                wr_q    <= req_write;
                wdata_q <= req_wdata;
            end
            if (accept && (state_q == ST_IDLE)) begin
                row_q   <= req_row;
                mask_q  <= req_mask;
                first_q <= 1'b1;
            end else if ((state_q == ST_CAS_LOW) && cas_done) begin
                first_q <= 1'b0;
            end
        end
    end

    // ---------------- pin decode ----------------
    always_comb begin
        dram_ras_n  = !row_open(state_q);
        dram_cas_n  = 1'b1;
        dram_we_n   = 1'b1;
        dram_oe_n   = 1'b1;
        dram_addr   = ADDR_W'(col_q);
        dram_dq_out = wdata_q;
        dram_dq_oe  = 1'b0;
        unique case (state_q)
            ST_ROW_SETUP, ST_RAS_FALL: begin
                dram_addr   = ADDR_W'(row_q);
                dram_dq_out = mask_q;
                dram_dq_oe  = 1'b1;
            end
            ST_COL_SETUP: begin
                dram_we_n  = !wr_q;
                dram_dq_oe = wr_q;
            end
            ST_CAS_LOW: begin
                dram_cas_n = 1'b0;
                dram_we_n  = !wr_q;
                dram_oe_n  = wr_q;
                dram_dq_oe = wr_q;
            end
            default: begin
            end
        endcase
    end

    pds_rd_capture #(.DATA_W(DATA_W)) u_rd_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .dq_in    (dram_dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // ---------------- assertions ----------------
    // R10
    ras_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_ras_n |-> (ras_age <= MAX_A));

    // R3
    cas_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);

    // R2
    mask_at_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (dram_dq_oe && (dram_dq_out == mask_q)));

    // R3
    col_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> $stable(dram_addr));

    // R7
    rd_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!dram_oe_n && !dram_cas_n));

    // R6
    wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_cas_n && !dram_we_n) |-> dram_dq_oe);

    // R11
    precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |=> dram_ras_n);

endmodule

// File: tb/page_dram_seq_tb.sv
module page_dram_seq_tb;
    localparam int T_ASR    = 2;
    localparam int T_ASC    = 1;
    localparam int T_CAC    = 2;
    localparam int T_RAC    = 6;
    localparam int T_CP     = 1;
    localparam int T_RP     = 3;
    localparam int RAS_MAX  = 40;
    localparam int IDLE_MAX = 5;

    typedef struct packed {
        logic [7:0] row;
        logic [7:0] col;
        logic       wr;
        logic [7:0] wdata;
        logic [7:0] mask;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_write = 1'b0;
    logic [7:0] req_row = '0;
    logic [7:0] req_col = '0;
    logic [7:0] req_wdata = '0;
    logic [7:0] req_mask = '0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [7:0] dram_addr, dram_dq_out;
    logic [7:0] dram_dq_in = '0;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    item_t      expq[$];
    logic [7:0] rdq[$];

    always #10 clk = ~clk;

    page_dram_seq #(
        .ROW_W(8), .COL_W(8), .DATA_W(8),
        .T_ASR(T_ASR), .T_ASC(T_ASC), .T_CAC(T_CAC), .T_RAC(T_RAC),
        .T_CP(T_CP), .T_RP(T_RP), .RAS_MAX(RAS_MAX), .IDLE_MAX(IDLE_MAX)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata), .req_mask(req_mask),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    function automatic logic [7:0] pat(input logic [7:0] r, input logic [7:0] c);
        return r ^ {c[3:0], c[7:4]} ^ 8'h3C;
    endfunction

    function automatic int first_pulse();
        int k = T_CAC;
        if (T_RAC - 1 - T_ASC > k) k = T_RAC - 1 - T_ASC;
        return k;
    endfunction

    // Row-strobe low length and pulse count of a page filled by back-to-back same-row requests.
    function automatic int burst_ras_len(output int pulses);
        int acc = T_ASC + T_CAC + T_CP + 1;
        int a = 1 + T_ASC + first_pulse() + T_CP + 1;
        pulses = 1;
        while (a + acc <= RAS_MAX) begin
            a += acc;
            pulses++;
        end
        return a;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Driver: call at a falling clock edge; returns at the falling edge after the handshake.
    task automatic send(input logic [7:0] r, input logic [7:0] c, input logic w,
                        input logic [7:0] d, input logic [7:0] m);
        bit got;
        item_t it;
        req_valid = 1'b1; req_row = r; req_col = c; req_write = w;
        req_wdata = d; req_mask = m;
        do begin
            #1;
            got = req_ready;
            if (got) begin
                it = '{row: r, col: c, wr: w, wdata: d, mask: m};
                expq.push_back(it);
                if (!w) rdq.push_back(pat(r, c));
            end
            @(negedge clk);
        end while (!got);
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // ---------------- pin monitor and DRAM model ----------------
    logic       prev_ras = 1'b1, prev_cas = 1'b1;
    logic [7:0] prev_addr = '0;
    int addr_stable = 0, ras_low_cnt = 0, ras_high_cnt = 0, cas_low_cnt = 0;
    int cas_high_cnt = 0, cas_in_row = 0, tail = 0;
    int last_ras_len = 0, last_cas_count = 0, last_tail = 0;
    bit seen_ras = 0, first_in_row = 0;
    logic [7:0] cur_row = '0;

    always @(negedge clk) begin
        item_t it;
        logic [7:0] exp_rd;
        if (rst_n) begin
            // row strobe falls
            if (prev_ras && !dram_ras_n) begin
                check((dram_addr == prev_addr) && (addr_stable >= T_ASR), "R2 row setup",
                      addr_stable, T_ASR);
                if (seen_ras) check(ras_high_cnt >= T_RP, "R11 precharge", ras_high_cnt, T_RP);
                if (expq.size() > 0) begin
                    it = expq[0];
                    check(dram_dq_oe && (dram_dq_out == it.mask), "R2 mask at row fall",
                          dram_dq_out, it.mask);
                end
                cur_row = dram_addr;
                seen_ras = 1; first_in_row = 1; cas_in_row = 0;
            end
            // column strobe falls
            if (prev_cas && !dram_cas_n) begin
                check(!dram_ras_n, "R3 row low during pulse", dram_ras_n, 0);
                check((dram_addr == prev_addr) && (addr_stable >= T_ASC), "R3 col setup",
                      addr_stable, T_ASC);
                if (!first_in_row) check(cas_high_cnt >= T_CP, "R3 col precharge", cas_high_cnt, T_CP);
                if (expq.size() == 0) begin
                    check(0, "R3 unexpected pulse", 1, 0);
                end else begin
                    it = expq.pop_front();
                    check(cur_row == it.row, "R8 row of access", cur_row, it.row);
                    check(dram_addr == it.col, "R3 column of access", dram_addr, it.col);
                    if (it.wr) begin
                        check(!dram_we_n && dram_dq_oe && (dram_dq_out == it.wdata),
                              "R6 write drive", dram_dq_out, it.wdata);
                    end else begin
                        check(dram_we_n && !dram_oe_n, "R6 read enables",
                              {dram_we_n, dram_oe_n}, 2);
                    end
                end
                tail = 0;
            end
            // column strobe rises
            if (!prev_cas && dram_cas_n) begin
                if (first_in_row) check(cas_low_cnt == first_pulse(), "R4 first pulse length",
                                        cas_low_cnt, first_pulse());
                else check(cas_low_cnt == T_CAC, "R5 later pulse length", cas_low_cnt, T_CAC);
                first_in_row = 0;
                cas_in_row++;
            end
            // row strobe rises
            if (!prev_ras && dram_ras_n) begin
                check(ras_low_cnt <= RAS_MAX, "R10 row low limit", ras_low_cnt, RAS_MAX);
                last_ras_len = ras_low_cnt;
                last_cas_count = cas_in_row;
                last_tail = tail;
            end
            // returned read data
            if (rd_valid) begin
                if (rdq.size() == 0) begin
                    check(0, "R7 unexpected read data", rd_data, 0);
                end else begin
                    exp_rd = rdq.pop_front();
                    check(rd_data == exp_rd, "R7 R4 R5 read data", rd_data, exp_rd);
                end
            end
            // counters
            addr_stable  = (dram_addr == prev_addr) ? addr_stable + 1 : 1;
            ras_low_cnt  = dram_ras_n ? 0 : ras_low_cnt + 1;
            ras_high_cnt = dram_ras_n ? ras_high_cnt + 1 : 0;
            cas_low_cnt  = dram_cas_n ? 0 : cas_low_cnt + 1;
            cas_high_cnt = dram_cas_n ? cas_high_cnt + 1 : 0;
            if (!dram_ras_n && dram_cas_n && (cas_in_row > 0)) tail++;
            prev_ras  = dram_ras_n;
            prev_cas  = dram_cas_n;
            prev_addr = dram_addr;
            // DRAM model: correct data only once both access times are met
            if (!dram_ras_n && !dram_cas_n && !dram_oe_n &&
                (cas_low_cnt >= T_CAC) && (ras_low_cnt >= T_RAC))
                dram_dq_in = pat(cur_row, dram_addr);
            else
                dram_dq_in = ~pat(cur_row, dram_addr);
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
        summary();
    end

    // ---------------- stimulus ----------------
    initial begin
        int exp_pulses;
        int exp_len;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1
        check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes idle",
              {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
        check(!dram_dq_oe && !rd_valid, "R1 no drive no data", {dram_dq_oe, rd_valid}, 0);
        check(req_ready, "R1 ready", req_ready, 1);
        @(negedge clk);

        // Row 0x12: three writes then two reads in one page (R3, R6); a later mask is ignored.
        send(8'h12, 8'h01, 1'b1, 8'hA1, 8'hA5);
        send(8'h12, 8'h02, 1'b1, 8'hB2, 8'h00);
        send(8'h12, 8'h03, 1'b1, 8'hC3, 8'h00);
        send(8'h12, 8'h02, 1'b0, 8'h00, 8'h00);
        send(8'h12, 8'h40, 1'b0, 8'h00, 8'h00);
        // R8: different row closes the page at once
        send(8'h34, 8'h07, 1'b0, 8'h00, 8'h5A);
        check(last_cas_count == 5, "R3 pulses in page", last_cas_count, 5);
        check(last_tail == T_CP + 1, "R8 close on row change", last_tail, T_CP + 1);

        // R9: idle close
        idle(30);
        check(last_cas_count == 1, "R9 pulses in page", last_cas_count, 1);
        check(last_tail == T_CP + IDLE_MAX, "R9 idle close", last_tail, T_CP + IDLE_MAX);

        // R10: long same-row burst is cut by the row-time budget
        exp_len = burst_ras_len(exp_pulses);
        for (int i = 0; i < 10; i++) begin
            send(8'h77, 8'(i * 3), 1'(i % 2), 8'(8'h90 + i), 8'h0F);
            if (i == exp_pulses) begin
                check(last_cas_count == exp_pulses, "R10 pulses before forced close",
                      last_cas_count, exp_pulses);
                check(last_ras_len == exp_len, "R10 row low length", last_ras_len, exp_len);
            end
        end
        idle(40);
        check(expq.size() == 0, "R3 all accesses issued", expq.size(), 0);
        check(rdq.size() == 0, "R7 all reads returned", rdq.size(), 0);
        summary();
    end
endmodule